// File: doc/BRIEF.md
# Systolic Matrix Multiply Sequencer

This block is the control state machine for one matrix product on a systolic array. It takes status flags from the operand and result datapaths and returns the strobes that steer them. Operand words arrive one per input handshake. After each word the sequencer either asks for another word, advancing the row and column indices, or starts the array once the operand store reports full. It then alternates between loading the feeders and waiting for each partial product. When the array reports a finished result, it latches the result buffer and sends the result out in chunks, one output handshake per chunk.

After the last chunk it returns to idle and gives a one-cycle completion pulse. It also pulses the row and column advance strobes, so that the external index counters wrap back to zero. Every output comes straight from a register. The levels (input ready, output valid) follow the state that was just entered. The strobes are one-cycle pulses that mark the transition just taken.

Top module: `sa_mm_ctrl`

## Requirements
- R1: While `rst_ni` is low every output is low, and on release the sequencer is idle: an input handshake flag alone raises nothing.
- R2: `start_i` sampled in idle raises `in_ready_o` on the next cycle. It stays high until `in_xfer_i` is sampled and drops on the cycle after that.
- R3: After an accepted word, if `opnd_full_i` is low in the following cycle, `in_ready_o` rises again two cycles after the word. It rises together with one-cycle pulses on `next_row_o` and `next_col_o`.
- R4: After an accepted word, if `opnd_full_i` is high in the following cycle, `feed_load_o` pulses on the next cycle without `feed_shift_o` and without index pulses.
- R5: In the cycle when `feed_load_o` is high, a low `res_valid_i` leads to waiting for `pe_done_i`. On `pe_done_i`, `feed_load_o` and `feed_shift_o` pulse together for one cycle. This repeats for any number of partial products.
- R6: In the cycle when `feed_load_o` is high, a high `res_valid_i` gives a `buf_capture_o` pulse two cycles later. On the cycle after that, `out_load_o` pulses and `out_valid_o` rises.
- R7: `out_valid_o` holds until `out_xfer_i`. When `out_xfer_i` is sampled with `last_chunk_i` low, the next cycle has `out_valid_o` low and `out_shift_o` high. The cycle after that has `out_valid_o` high again.
- R8: When `out_xfer_i` and `last_chunk_i` are sampled together while `out_valid_o` is high, the next cycle has `mult_done_o`, `next_row_o` and `next_col_o` high for one cycle and `out_valid_o` low. The sequencer is then idle.
- R9: Flags that do not belong to the current phase have no effect. This covers the datapath flags in idle, and `start_i`, `pe_done_i`, `out_xfer_i` and `last_chunk_i` while waiting for an operand.
- R10: `in_ready_o` is never high together with `out_valid_o`, `feed_load_o`, `buf_capture_o` or `out_shift_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a multiplication |
| in_xfer_i | input | 1 | Operand word handshake completed |
| opnd_full_i | input | 1 | All operand rows and columns stored |
| res_valid_i | input | 1 | Array result is complete |
| pe_done_i | input | 1 | Current partial product finished |
| out_xfer_i | input | 1 | Result chunk handshake completed |
| last_chunk_i | input | 1 | Chunk in flight is the final one |
| in_ready_o | output | 1 | Ready toward the operand source |
| next_row_o | output | 1 | Advance row index pulse |
| next_col_o | output | 1 | Advance column index pulse |
| feed_load_o | output | 1 | Load all data feeders pulse |
| feed_shift_o | output | 1 | Shift all data feeders pulse |
| buf_capture_o | output | 1 | Latch array result into buffer pulse |
| out_load_o | output | 1 | Load output chunk feeder pulse |
| out_valid_o | output | 1 | Valid toward the result sink |
| out_shift_o | output | 1 | Shift output chunk feeder pulse |
| mult_done_o | output | 1 | Multiplication finished pulse |

## Verification
The bound checker watches rules that can be seen on every cycle. Input ready drops after a handshake, and feeder shifts only come with feeder loads. It also checks the capture-then-load order, the chunk step and final-chunk responses to an output handshake, the one-cycle completion pulse, and the exclusion between input ready and the output phases. What only the bench scenarios can show are the cycle counts and the path choices. These are the two-cycle gap before the next operand is requested, the full-or-not branch, repeated feed loops, and the flags that have no effect in idle and in receive. They also include the behaviour of an asynchronous reset in the middle of a run.

// File: rtl/sa_mm_ctrl_pkg.sv
package sa_mm_ctrl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_RECV  = 4'd1,
    ST_COUNT = 4'd2,
    ST_LOAD  = 4'd3,
    ST_FEED  = 4'd4,
    ST_PROC  = 4'd5,
    ST_DRAIN = 4'd6,
    ST_OUTLD = 4'd7,
    ST_XFER  = 4'd8,
    ST_STEP  = 4'd9
  } state_e;

  // transition events taken this cycle
  typedef struct packed {
    logic advance;
    logic feed_shift;
    logic capture;
    logic out_start;
    logic out_shift;
    logic finish;
  } event_t;

endpackage

// File: rtl/sa_mm_ctrl_fsm.sv
module sa_mm_ctrl_fsm
  import sa_mm_ctrl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   in_xfer_i,
  input  logic   opnd_full_i,
  input  logic   res_valid_i,
  input  logic   pe_done_i,
  input  logic   out_xfer_i,
  input  logic   last_chunk_i,
  output state_e nxt_o,
  output event_t ev_o
);

  state_e cur_q, nxt;
  event_t ev;

  always_comb begin
    nxt = cur_q;
    ev  = '0;
    unique case (cur_q)
      ST_IDLE:  if (start_i) nxt = ST_RECV;
      ST_RECV:  if (in_xfer_i) nxt = ST_COUNT;
      ST_COUNT: nxt = opnd_full_i ? ST_FEED : ST_LOAD;
      ST_LOAD: begin
        nxt        = ST_RECV;
        ev.advance = 1'b1;
      end
      ST_FEED:  nxt = res_valid_i ? ST_DRAIN : ST_PROC;
      ST_PROC: begin
        if (pe_done_i) begin
          nxt           = ST_FEED;
          ev.feed_shift = 1'b1;
        end
      end
      ST_DRAIN: begin
        nxt        = ST_OUTLD;
        ev.capture = 1'b1;
      end
      ST_OUTLD: begin
        nxt          = ST_XFER;
        ev.out_start = 1'b1;
      end
      ST_XFER: begin
        if (out_xfer_i && last_chunk_i) begin
          nxt        = ST_IDLE;
          ev.finish  = 1'b1;
          ev.advance = 1'b1; // wrap index counters
        end else if (out_xfer_i) begin
          nxt          = ST_STEP;
          ev.out_shift = 1'b1;
        end
      end
      ST_STEP:  nxt = ST_XFER;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= ST_IDLE;
    else         cur_q <= nxt;
  end

  assign nxt_o = nxt;
  assign ev_o  = ev;

endmodule

// File: rtl/sa_mm_ctrl_strobe.sv
module sa_mm_ctrl_strobe
  import sa_mm_ctrl_pkg::*;
#(
  parameter int unsigned NUM_OUT = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  state_e             nxt_i,
  input  event_t             ev_i,
  output logic [NUM_OUT-1:0] out_o
);

  // bit order: in_ready, next_row, next_col, feed_load, feed_shift,
  //            buf_capture, out_load, out_valid, out_shift, mult_done
  logic [NUM_OUT-1:0] d, q;

  always_comb begin
    d = '0;
    d[9] = (nxt_i == ST_RECV);
    d[8] = ev_i.advance;
    d[7] = ev_i.advance;
    d[6] = (nxt_i == ST_FEED);
    d[5] = ev_i.feed_shift;
    d[4] = ev_i.capture;
    d[3] = ev_i.out_start;
    d[2] = (nxt_i == ST_XFER);
    d[1] = ev_i.out_shift;
    d[0] = ev_i.finish;
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[g] <= 1'b0;
      else         q[g] <= d[g];
    end
  end

  assign out_o = q;

endmodule

// File: rtl/sa_mm_ctrl.sv
module sa_mm_ctrl
  import sa_mm_ctrl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic in_xfer_i,
  input  logic opnd_full_i,
  input  logic res_valid_i,
  input  logic pe_done_i,
  input  logic out_xfer_i,
  input  logic last_chunk_i,
  output logic in_ready_o,
  output logic next_row_o,
  output logic next_col_o,
  output logic feed_load_o,
  output logic feed_shift_o,
  output logic buf_capture_o,
  output logic out_load_o,
  output logic out_valid_o,
  output logic out_shift_o,
  output logic mult_done_o
);

  localparam int unsigned NumOut = 10;

  state_e              nxt;
  event_t              ev;
  logic [NumOut-1:0]   outs;

  sa_mm_ctrl_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .in_xfer_i    (in_xfer_i),
    .opnd_full_i  (opnd_full_i),
    .res_valid_i  (res_valid_i),
    .pe_done_i    (pe_done_i),
    .out_xfer_i   (out_xfer_i),
    .last_chunk_i (last_chunk_i),
    .nxt_o        (nxt),
    .ev_o         (ev)
  );

  sa_mm_ctrl_strobe #(.NUM_OUT(NumOut)) u_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nxt_i  (nxt),
    .ev_i   (ev),
    .out_o  (outs)
  );

  assign {in_ready_o, next_row_o, next_col_o, feed_load_o, feed_shift_o,
          buf_capture_o, out_load_o, out_valid_o, out_shift_o, mult_done_o} = outs;

endmodule

// File: rtl/sa_mm_ctrl_chk.sv
module sa_mm_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic in_xfer_i,
  input logic out_xfer_i,
  input logic last_chunk_i,
  input logic in_ready_o,
  input logic next_row_o,
  input logic next_col_o,
  input logic feed_load_o,
  input logic feed_shift_o,
  input logic buf_capture_o,
  input logic out_load_o,
  input logic out_valid_o,
  input logic out_shift_o,
  input logic mult_done_o
);

  // R2
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o && in_xfer_i |=> !in_ready_o);

  // R5
  shift_with_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed_shift_o |-> feed_load_o);

  // R6
  capture_then_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_capture_o |=> out_load_o && out_valid_o);

  // R7
  chunk_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_xfer_i && !last_chunk_i |=> out_shift_o && !out_valid_o);

  // R7
  step_revalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_shift_o |=> out_valid_o);

  // R8
  final_chunk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_xfer_i && last_chunk_i |=> mult_done_o && next_row_o && next_col_o && !out_valid_o);

  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mult_done_o |=> !mult_done_o);

  // R10
  phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({in_ready_o, out_valid_o, feed_load_o, buf_capture_o, out_shift_o}));

endmodule

bind sa_mm_ctrl sa_mm_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_xfer_i     (in_xfer_i),
  .out_xfer_i    (out_xfer_i),
  .last_chunk_i  (last_chunk_i),
  .in_ready_o    (in_ready_o),
  .next_row_o    (next_row_o),
  .next_col_o    (next_col_o),
  .feed_load_o   (feed_load_o),
  .feed_shift_o  (feed_shift_o),
  .buf_capture_o (buf_capture_o),
  .out_load_o    (out_load_o),
  .out_valid_o   (out_valid_o),
  .out_shift_o   (out_shift_o),
  .mult_done_o   (mult_done_o)
);

// File: tb/sa_mm_ctrl_test.sv
`timescale 1ns/1ps
module sa_mm_ctrl_test;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [6:0] vin = '0; // start, in_xfer, full, res_valid, pe_done, out_xfer, last
  logic [9:0] vout;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk; // 125 MHz

  sa_mm_ctrl uut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .start_i       (vin[6]),
    .in_xfer_i     (vin[5]),
    .opnd_full_i   (vin[4]),
    .res_valid_i   (vin[3]),
    .pe_done_i     (vin[2]),
    .out_xfer_i    (vin[1]),
    .last_chunk_i  (vin[0]),
    .in_ready_o    (vout[9]),
    .next_row_o    (vout[8]),
    .next_col_o    (vout[7]),
    .feed_load_o   (vout[6]),
    .feed_shift_o  (vout[5]),
    .buf_capture_o (vout[4]),
    .out_load_o    (vout[3]),
    .out_valid_o   (vout[2]),
    .out_shift_o   (vout[1]),
    .mult_done_o   (vout[0])
  );

  // {req[3:0], inputs[6:0], expected outputs after the edge[9:0]}
  localparam int NV = 22;
  localparam logic [20:0] VEC [NV] = '{
    {4'd2,  7'b1000000, 10'b1000000000}, // R2 start
    {4'd2,  7'b0000000, 10'b1000000000}, // R2 hold ready
    {4'd2,  7'b0100000, 10'b0000000000}, // R2 word accepted
    {4'd3,  7'b0000000, 10'b0000000000}, // R3 not full
    {4'd3,  7'b0000000, 10'b1110000000}, // R3 ready again + index pulses
    {4'd2,  7'b0100000, 10'b0000000000}, // R2 second word
    {4'd4,  7'b0010000, 10'b0001000000}, // R4 full -> feed
    {4'd5,  7'b0000000, 10'b0000000000}, // R5 processing
    {4'd5,  7'b0000000, 10'b0000000000}, // R5 wait
    {4'd5,  7'b0000100, 10'b0001100000}, // R5 load+shift
    {4'd6,  7'b0001000, 10'b0000000000}, // R6 result ready
    {4'd6,  7'b0000000, 10'b0000010000}, // R6 capture
    {4'd6,  7'b0000000, 10'b0000001100}, // R6 out load + valid
    {4'd7,  7'b0000000, 10'b0000000100}, // R7 valid held
    {4'd7,  7'b0000010, 10'b0000000010}, // R7 chunk step
    {4'd7,  7'b0000000, 10'b0000000100}, // R7 valid again
    {4'd8,  7'b0000011, 10'b0110000001}, // R8 final chunk
    {4'd8,  7'b0000000, 10'b0000000000}, // R8 idle, pulses single
    {4'd9,  7'b0111111, 10'b0000000000}, // R9 ignored in idle
    {4'd2,  7'b1000000, 10'b1000000000}, // R2 start again
    {4'd9,  7'b0000111, 10'b1000000000}, // R9 ignored in receive
    {4'd9,  7'b1000000, 10'b1000000000}  // R9 start ignored in receive
  };

  task automatic check(input logic [9:0] exp, input int req, input string what);
    n_chk++;
    if (vout !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: got %b expected %b", req, what, vout, exp);
    end
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    n_chk++;
    $display("FAIL R1 watchdog expired: got hang expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(10'b0, 1, "outputs in reset"); // R1
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      vin = VEC[i][16:10];
      @(posedge clk);
      #2;
      check(VEC[i][9:0], int'(VEC[i][20:17]), $sformatf("vector %0d", i));
    end

    // R1 asynchronous reset mid-run (currently receiving)
    @(negedge clk);
    vin = '0;
    rst_ni = 1'b0;
    #1;
    check(10'b0, 1, "async reset clears outputs");
    @(negedge clk);
    rst_ni = 1'b1;
    vin = 7'b0100000; // handshake flag alone after reset
    @(posedge clk);
    #2;
    check(10'b0, 1, "idle after reset ignores in_xfer");
    @(negedge clk);
    vin = 7'b1000000;
    @(posedge clk);
    #2;
    check(10'b1000000000, 2, "start after reset");

    @(negedge clk);
    vin = '0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule